// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps bus addresses that land in a graphics aperture window onto physical page addresses. The window starts at `ap_base` and spans 32, 64, 128 or 256 MB, set through a size code in a configuration register. The translation walks two levels. The first level is an on-chip directory of 64 slots, loaded one slot at a time through a packed configuration write. The second level is a set of 4 KB pages of 32-bit entries held in external memory and read through a request/response port. Recent successful translations are kept in a small fully associative buffer. Toggling a control bit from clear to set empties that buffer.

A translation request is a valid/ready stream. `req_ready` is high only while the block is idle, so it accepts one request at a time. A request is taken in a cycle where both `req_valid` and `req_ready` are high. The result appears on `rsp_valid` with `rsp_paddr` and `rsp_fault`. It is held without change until `rsp_ready` is seen high, which gives the consumer full back-pressure. The memory read request uses the same valid/ready rule. The memory response is a one-cycle `mem_rsp_valid` pulse and cannot be stalled.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, the buffer holds nothing, every directory slot is non-present, the size is 256 MB and the flush control bit is 0.
- R2: A configuration write to offset 0xB8 loads one directory slot. Bits 5:0 select the slot, bit 8 is the present flag and bits 31:12 are the second-level page address. Bits 11:9 and 7:6 have no effect. A write with bit 8 clear makes the slot non-present.
- R3: An address is inside the window only when `ap_base` <= address < `ap_base` + pages*4096. Outside the window the response is fault 1 with `rsp_paddr` 0, and no memory read is issued.
- R4: A configuration write to offset 0xB4 sets the size from bits 7:0. Code 0 gives 65536 pages, 32 gives 32768, 48 gives 16384 and 56 gives 8192. A write with any other code leaves the size unchanged.
- R5: The directory slot is address bits 31:22 minus `ap_base` bits 31:22. A request that misses the buffer and reaches a non-present slot gets fault 2 with `rsp_paddr` 0, and no memory read is issued.
- R6: A buffer miss on a present slot issues exactly one memory read, at {slot page address, address bits 21:12, 2'b00}.
- R7: A second-level entry with bit 0 set gives `rsp_paddr` = {entry bits 31:12, address bits 11:0} and fault 0. An entry with bit 0 clear gives fault 3 with `rsp_paddr` 0 and is not kept in the buffer.
- R8: The buffer holds 4 pages, tagged by address bits 31:12, and replaces them in round-robin order. A hit gives its response in the cycle after acceptance and issues no memory read.
- R9: A write to offset 0xB0 that sets bit 7 while the stored bit 7 is 0 empties the buffer. A write that sets bit 7 while it is already 1 empties nothing.
- R10: If the buffer is emptied while a memory read is pending, that translation is still returned but is not kept in the buffer.
- R11: Directory writes leave translations already in the buffer unchanged until the buffer is emptied.
- R12: `req_ready` is low whenever a response or a memory read is pending. `rsp_valid` and its data stay stable until `rsp_ready`. `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready`. Each accepted read request drops `mem_req_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ap_base | input | 32 | Aperture base address, 4 MB aligned |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request may be taken |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1 outside, 2 slot absent, 3 entry invalid |
| mem_req_valid | output | 1 | Second-level read request valid |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid pulse |
| mem_rsp_data | input | 32 | Second-level entry |

## Verification
The assertions check the stream rules on every cycle. They cover stable held responses and read requests, `req_ready` staying low during outstanding work, a single read per miss, a zero address with any fault, and at most one matching buffer entry. Only the bench scenarios can show the translation arithmetic, the window limits under each size code, and the round-robin eviction order. The same holds for the difference between a flush edge and a repeated set, and for a flush during a walk causing no fill.

// File: rtl/ax_pkg.sv
package ax_pkg;
  localparam int ADDR_W     = 32;
  localparam int PG_SHIFT   = 12;
  localparam int L2_BITS    = 10;
  localparam int VPN_W      = ADDR_W - PG_SHIFT;
  localparam int DIRSEL_LSB = PG_SHIFT + L2_BITS;
  localparam int DIRSEL_W   = ADDR_W - DIRSEL_LSB;
  localparam int PGCNT_W    = 17;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_OUTSIDE = 2'd1,
    FLT_NODIR   = 2'd2,
    FLT_NOPTE   = 2'd3
  } ax_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RDREQ, ST_RDWAIT, ST_RESP
  } ax_state_e;

  typedef struct packed {
    logic             present;
    logic [VPN_W-1:0] ppn;
  } ax_dir_t;

  function automatic logic size_code_ok(input logic [7:0] code);
    return (code == 8'd0) || (code == 8'd32) || (code == 8'd48) || (code == 8'd56);
  endfunction

  function automatic logic [PGCNT_W-1:0] size_code_pages(input logic [7:0] code);
    case (code)
      8'd0:    return PGCNT_W'(65536);
      8'd32:   return PGCNT_W'(32768);
      8'd48:   return PGCNT_W'(16384);
      default: return PGCNT_W'(8192);
    endcase
  endfunction
endpackage

// File: rtl/ax_cfg_regs.sv
module ax_cfg_regs
  import ax_pkg::*;
#(
  parameter int DIR_ENTRIES = 64,
  parameter int CFG_AW      = 8,
  parameter int DIR_OFS     = 'hB8,
  parameter int SIZE_OFS    = 'hB4,
  parameter int CTRL_OFS    = 'hB0,
  localparam int DIR_W      = $clog2(DIR_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CFG_AW-1:0]  wr_addr,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic [DIR_W-1:0]   dir_idx,
  output ax_dir_t            dir_entry,
  output logic [PGCNT_W-1:0] ap_pages,
  output logic               flush
);
  localparam int PRESENT_BIT = 8;
  localparam int FLUSH_BIT   = 7;

  logic dir_wr, size_wr, ctrl_wr;
  logic flush_bit_q;
  logic [PGCNT_W-1:0] pages_q;
  ax_dir_t dir_q [DIR_ENTRIES];
  logic unused_attr;

  assign dir_wr  = wr_en && (wr_addr == CFG_AW'(DIR_OFS));
  assign size_wr = wr_en && (wr_addr == CFG_AW'(SIZE_OFS));
  assign ctrl_wr = wr_en && (wr_addr == CFG_AW'(CTRL_OFS));
  // Attribute index bits carry no meaning for the lookup.
  assign unused_attr = ^wr_data[11:9];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < DIR_ENTRIES; s++) dir_q[s] <= '0;
    end else if (dir_wr) begin
      for (int s = 0; s < DIR_ENTRIES; s++) begin
        if (wr_data[DIR_W-1:0] == DIR_W'(s)) begin
          dir_q[s].present <= wr_data[PRESENT_BIT];
          dir_q[s].ppn     <= wr_data[ADDR_W-1:PG_SHIFT];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pages_q     <= size_code_pages(8'd0);
      flush_bit_q <= 1'b0;
    end else begin
      if (size_wr && size_code_ok(wr_data[7:0])) pages_q <= size_code_pages(wr_data[7:0]);
      if (ctrl_wr) flush_bit_q <= wr_data[FLUSH_BIT];
    end
  end

  assign dir_entry = dir_q[dir_idx];
  assign ap_pages  = pages_q;
  assign flush     = ctrl_wr && wr_data[FLUSH_BIT] && !flush_bit_q;
endmodule

// File: rtl/ax_tlb.sv
module ax_tlb
  import ax_pkg::*;
#(
  parameter int DEPTH   = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [VPN_W-1:0] hit_ppn,
  output logic [DEPTH-1:0] hit_vec,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] fill_ppn
);
  logic [DEPTH-1:0] vld_q;
  logic [VPN_W-1:0] tag_q [DEPTH];
  logic [VPN_W-1:0] ppn_q [DEPTH];
  logic [PTR_W-1:0] rr_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign hit_vec[e] = vld_q[e] && (tag_q[e] == lk_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (hit_vec[e]) hit_ppn = hit_ppn | ppn_q[e];
    end
  end
  assign hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (fill_en) begin
      vld_q[rr_q] <= 1'b1;
      rr_q        <= (rr_q == PTR_W'(DEPTH-1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[rr_q] <= fill_vpn;
      ppn_q[rr_q] <= fill_ppn;
    end
  end
endmodule

// File: rtl/ax_walker.sv
module ax_walker
  import ax_pkg::*;
#(
  parameter int DIR_ENTRIES = 64,
  localparam int DIR_W      = $clog2(DIR_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  ap_base,
  input  logic [PGCNT_W-1:0] ap_pages,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_paddr,
  output logic [1:0]         rsp_fault,
  output logic [DIR_W-1:0]   dir_idx,
  input  ax_dir_t            dir_entry,
  output logic [VPN_W-1:0]   lk_vpn,
  input  logic               tlb_hit,
  input  logic [VPN_W-1:0]   tlb_ppn,
  input  logic               flush,
  output logic               fill_en,
  output logic [VPN_W-1:0]   fill_vpn,
  output logic [VPN_W-1:0]   fill_ppn,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rsp_data
);
  ax_state_e st_q;
  ax_fault_e fault_q;
  logic [ADDR_W-1:0]   paddr_q, rdaddr_q, off;
  logic [VPN_W-1:0]    vpn_q;
  logic [PG_SHIFT-1:0] ofs_q;
  logic                drop_q;
  logic [DIRSEL_W-1:0] dsel;
  logic outside, dir_ok, accept;
  logic unused_bits;

  assign off     = req_addr - ap_base;
  assign outside = (req_addr < ap_base) ||
                   (off[ADDR_W-1:PG_SHIFT] >= VPN_W'(ap_pages));
  assign dsel    = req_addr[ADDR_W-1:DIRSEL_LSB] - ap_base[ADDR_W-1:DIRSEL_LSB];
  assign dir_idx = dsel[DIR_W-1:0];
  assign dir_ok  = dir_entry.present && ((dsel >> DIR_W) == '0);
  assign lk_vpn  = req_addr[ADDR_W-1:PG_SHIFT];
  assign accept  = req_valid && (st_q == ST_IDLE);
  assign unused_bits = ^{off[PG_SHIFT-1:0], mem_rsp_data[PG_SHIFT-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      fault_q  <= FLT_NONE;
      paddr_q  <= '0;
      rdaddr_q <= '0;
      vpn_q    <= '0;
      ofs_q    <= '0;
      drop_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          vpn_q  <= lk_vpn;
          ofs_q  <= req_addr[PG_SHIFT-1:0];
          drop_q <= 1'b0;
          if (outside) begin
            fault_q <= FLT_OUTSIDE;
            paddr_q <= '0;
            st_q    <= ST_RESP;
          end else if (tlb_hit) begin
            fault_q <= FLT_NONE;
            paddr_q <= {tlb_ppn, req_addr[PG_SHIFT-1:0]};
            st_q    <= ST_RESP;
          end else if (!dir_ok) begin
            fault_q <= FLT_NODIR;
            paddr_q <= '0;
            st_q    <= ST_RESP;
          end else begin
            rdaddr_q <= {dir_entry.ppn, req_addr[DIRSEL_LSB-1:PG_SHIFT], 2'b00};
            st_q     <= ST_RDREQ;
          end
        end
        ST_RDREQ: begin
          if (flush) drop_q <= 1'b1;
          if (mem_req_ready) st_q <= ST_RDWAIT;
        end
        ST_RDWAIT: begin
          if (flush) drop_q <= 1'b1;
          if (mem_rsp_valid) begin
            st_q <= ST_RESP;
            if (mem_rsp_data[0]) begin
              fault_q <= FLT_NONE;
              paddr_q <= {mem_rsp_data[ADDR_W-1:PG_SHIFT], ofs_q};
            end else begin
              fault_q <= FLT_NOPTE;
              paddr_q <= '0;
            end
          end
        end
        default: if (rsp_ready) st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = (st_q == ST_RDREQ);
  assign mem_req_addr  = rdaddr_q;
  assign fill_en  = (st_q == ST_RDWAIT) && mem_rsp_valid && mem_rsp_data[0] && !drop_q;
  assign fill_vpn = vpn_q;
  assign fill_ppn = mem_rsp_data[ADDR_W-1:PG_SHIFT];
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import ax_pkg::*;
#(
  parameter int DIR_ENTRIES = 64,
  parameter int TLB_DEPTH   = 4,
  parameter int CFG_AW      = 8,
  parameter int DIR_OFS     = 'hB8,
  parameter int SIZE_OFS    = 'hB4,
  parameter int CTRL_OFS    = 'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ap_base,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  localparam int DIR_W = $clog2(DIR_ENTRIES);

  logic [DIR_W-1:0]     dir_idx;
  ax_dir_t              dir_entry;
  logic [PGCNT_W-1:0]   ap_pages;
  logic                 flush;
  logic [VPN_W-1:0]     lk_vpn, tlb_ppn, fill_vpn, fill_ppn;
  logic                 tlb_hit, fill_en;
  logic [TLB_DEPTH-1:0] tlb_hit_vec;

  ax_cfg_regs #(
    .DIR_ENTRIES(DIR_ENTRIES), .CFG_AW(CFG_AW),
    .DIR_OFS(DIR_OFS), .SIZE_OFS(SIZE_OFS), .CTRL_OFS(CTRL_OFS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .dir_idx(dir_idx), .dir_entry(dir_entry),
    .ap_pages(ap_pages), .flush(flush)
  );

  ax_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .hit(tlb_hit),
    .hit_ppn(tlb_ppn), .hit_vec(tlb_hit_vec), .flush(flush),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
  );

  ax_walker #(.DIR_ENTRIES(DIR_ENTRIES)) u_walk (
    .clk(clk), .rst_n(rst_n), .ap_base(ap_base), .ap_pages(ap_pages),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .dir_idx(dir_idx), .dir_entry(dir_entry),
    .lk_vpn(lk_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .flush(flush),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );
endmodule

// File: rtl/ax_chk.sv
module ax_chk #(
  parameter int TLB_DEPTH = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [31:0]          rsp_paddr,
  input logic [1:0]           rsp_fault,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic [31:0]          mem_req_addr,
  input logic [TLB_DEPTH-1:0] tlb_hit_vec
);
  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R12
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R12
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  // R6
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R3
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 2'd0) |-> (rsp_paddr == 32'd0));

  // R8
  tlb_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_hit_vec));
endmodule

bind aperture_xlate ax_chk #(.TLB_DEPTH(TLB_DEPTH)) u_ax_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .tlb_hit_vec(tlb_hit_vec)
);

// File: tb/sim_aperture_xlate.sv
module sim_aperture_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ap_base = 32'h8000_0000;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int n_chk = 0;
  int n_err = 0;
  int rd_count = 0;
  logic [31:0] last_rd = '0;

  localparam logic [7:0] OFS_DIR = 8'hB8, OFS_SIZE = 8'hB4, OFS_CTRL = 8'hB0;
  localparam logic [19:0] D0 = 20'h00100, D1 = 20'h00203, D63 = 20'h00FFF;
  localparam logic [31:0] P0 = 32'h8000_1000, P1 = 32'h8000_2000, P2 = 32'h8040_3000,
                          P3 = 32'h8040_4000, P4 = 32'h8000_6000;

  always #2 clk = ~clk;

  aperture_xlate u0 (
    .clk(clk), .rst_n(rst_n), .ap_base(ap_base), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // Second-level memory model: entry index 0x3FF is unmapped (all zero).
  function automatic logic [31:0] pte_model(input logic [31:0] a);
    if (a[11:2] == 10'h3FF) return 32'd0;
    return {a[31:12] + {10'd0, a[11:2]} + 20'h00777, 11'd0, 1'b1};
  endfunction

  function automatic logic [31:0] exp_pa(input logic [19:0] d, input logic [31:0] a);
    logic [31:0] p;
    p = pte_model({d, a[21:12], 2'b00});
    return {p[31:12], a[11:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= pte_model(mem_req_addr);
      if (mem_req_valid && mem_req_ready) begin
        rd_count <= rd_count + 1;
        last_rd  <= mem_req_addr;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic do_flush();
    cfg_write(OFS_CTRL, 32'h2200);
    cfg_write(OFS_CTRL, 32'h2280);
  endtask

  task automatic xlate(input logic [31:0] a, output logic [31:0] pa, output logic [1:0] f,
                       output int nrd, output int lat);
    int r0;
    r0 = rd_count;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    pa = rsp_paddr; f = rsp_fault;
    @(negedge clk);
    nrd = rd_count - r0;
  endtask

  task automatic expect_x(input string tag, input logic [31:0] a, input logic [31:0] epa,
                          input logic [1:0] ef, input int erd);
    logic [31:0] pa; logic [1:0] f; int nrd, lat;
    xlate(a, pa, f, nrd, lat);
    check({tag, " fault"}, {30'd0, f}, {30'd0, ef});
    check({tag, " paddr"}, pa, epa);
    check({tag, " reads"}, nrd, erd);
  endtask

  task automatic t_reset();
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    expect_x("R1 R5 empty directory", 32'h8000_5123, 32'd0, 2'd2, 0);
  endtask

  task automatic t_walk();
    logic [31:0] pa; logic [1:0] f; int nrd, lat;
    cfg_write(OFS_DIR, {D0, 12'h0} | 32'h0000_0F00);
    cfg_write(OFS_DIR, {D1, 12'h0} | 32'h0000_0101);
    cfg_write(OFS_DIR, {D63, 12'h0} | 32'h0000_013F);
    expect_x("R2 R6 R7 miss slot0", 32'h8000_5123, exp_pa(D0, 32'h8000_5123), 2'd0, 1);
    check("R6 read address slot0", last_rd, 32'h0010_0014);
    expect_x("R5 miss slot1", 32'h8040_2008, exp_pa(D1, 32'h8040_2008), 2'd0, 1);
    check("R5 read address slot1", last_rd, 32'h0020_3008);
    expect_x("R2 slot63", 32'h8FFF_E010, exp_pa(D63, 32'h8FFF_E010), 2'd0, 1);
    check("R2 read address slot63", last_rd, 32'h00FF_FFF8);
    xlate(32'h8000_5ABC, pa, f, nrd, lat);
    check("R8 hit paddr", pa, exp_pa(D0, 32'h8000_5ABC));
    check("R8 hit reads", nrd, 0);
    check("R8 hit latency", lat, 1);
  endtask

  task automatic t_unmapped();
    expect_x("R7 invalid entry", 32'h803F_F000, 32'd0, 2'd3, 1);
    expect_x("R7 invalid not kept", 32'h803F_F000, 32'd0, 2'd3, 1);
  endtask

  task automatic t_outside();
    expect_x("R3 below base", 32'h7FFF_F000, 32'd0, 2'd1, 0);
    expect_x("R3 at end", 32'h9000_0000, 32'd0, 2'd1, 0);
    expect_x("R3 last page", 32'h8FFF_FFFF, 32'd0, 2'd3, 1);
  endtask

  task automatic t_size();
    cfg_write(OFS_SIZE, 32'd56);
    expect_x("R4 32MB end", 32'h8200_0000, 32'd0, 2'd1, 0);
    expect_x("R4 32MB last", 32'h81FF_F000, 32'd0, 2'd2, 0);
    cfg_write(OFS_SIZE, 32'd48);
    expect_x("R4 64MB inside", 32'h8200_0000, 32'd0, 2'd2, 0);
    expect_x("R4 64MB end", 32'h8400_0000, 32'd0, 2'd1, 0);
    cfg_write(OFS_SIZE, 32'h11);
    expect_x("R4 bad code kept", 32'h8400_0000, 32'd0, 2'd1, 0);
    expect_x("R4 bad code last", 32'h83FF_F000, 32'd0, 2'd2, 0);
    cfg_write(OFS_SIZE, 32'd0);
    expect_x("R4 256MB again", 32'h8400_0000, 32'd0, 2'd2, 0);
  endtask

  task automatic t_round_robin();
    do_flush();
    expect_x("R8 fill P0", P0, exp_pa(D0, P0), 2'd0, 1);
    expect_x("R8 fill P1", P1, exp_pa(D0, P1), 2'd0, 1);
    expect_x("R8 fill P2", P2, exp_pa(D1, P2), 2'd0, 1);
    expect_x("R8 fill P3", P3, exp_pa(D1, P3), 2'd0, 1);
    expect_x("R8 hit P0", P0, exp_pa(D0, P0), 2'd0, 0);
    expect_x("R8 hit P3", P3, exp_pa(D1, P3), 2'd0, 0);
    expect_x("R8 evict P0", P4, exp_pa(D0, P4), 2'd0, 1);
    expect_x("R8 P1 kept", P1, exp_pa(D0, P1), 2'd0, 0);
    expect_x("R8 P0 evicted", P0, exp_pa(D0, P0), 2'd0, 1);
    expect_x("R8 P2 kept", P2, exp_pa(D1, P2), 2'd0, 0);
    expect_x("R8 P1 evicted", P1, exp_pa(D0, P1), 2'd0, 1);
  endtask

  task automatic t_flush();
    cfg_write(OFS_CTRL, 32'h2280);
    expect_x("R9 repeated set keeps", P4, exp_pa(D0, P4), 2'd0, 0);
    do_flush();
    expect_x("R9 flushed", P4, exp_pa(D0, P4), 2'd0, 1);
  endtask

  task automatic t_dir_keep();
    cfg_write(OFS_DIR, 32'h0000_0000);
    expect_x("R11 cached survives", P4, exp_pa(D0, P4), 2'd0, 0);
    expect_x("R2 slot cleared", P0, 32'd0, 2'd2, 0);
    do_flush();
    expect_x("R11 after flush", P4, 32'd0, 2'd2, 0);
    cfg_write(OFS_DIR, {D0, 12'h0} | 32'h0000_0100);
  endtask

  task automatic t_flush_walk();
    logic [31:0] held;
    mem_req_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = P1 + 32'h44;
    @(negedge clk);
    req_valid = 1'b0;
    held = mem_req_addr;
    cfg_write(OFS_CTRL, 32'h2200);
    cfg_write(OFS_CTRL, 32'h2280);
    check("R12 read held", {31'd0, mem_req_valid}, 32'd1);
    check("R12 read addr stable", mem_req_addr, held);
    check("R12 busy", {31'd0, req_ready}, 32'd0);
    mem_req_ready = 1'b1;
    while (!rsp_valid) @(negedge clk);
    check("R10 result returned", rsp_paddr, exp_pa(D0, P1 + 32'h44));
    @(negedge clk);
    expect_x("R10 not kept", P1, exp_pa(D0, P1), 2'd0, 1);
    expect_x("R10 refill hit", P1, exp_pa(D0, P1), 2'd0, 0);
  endtask

  task automatic t_hold();
    logic [31:0] first;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = P1 + 32'h8;
    @(negedge clk);
    req_valid = 1'b0;
    first = rsp_paddr;
    check("R12 response value", first, exp_pa(D0, P1 + 32'h8));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R12 rsp held", {31'd0, rsp_valid}, 32'd1);
      check("R12 rsp stable", rsp_paddr, first);
      check("R12 no accept", {31'd0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R12 rsp taken", {31'd0, rsp_valid}, 32'd0);
    check("R12 ready again", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk();
    t_unmapped();
    t_outside();
    t_size();
    t_round_robin();
    t_flush();
    t_dir_keep();
    t_flush_walk();
    t_hold();
    finish_run();
  end
endmodule